// File: doc/BRIEF.md
# Retention-Binned Row Refresh Scheduler

This block sits in a DRAM memory controller and decides which rows need a refresh command in each base period. Rows with weak cells get refreshed often, and healthy rows get refreshed rarely. The block does not refresh every row uniformly once per retention window. Before operation, software records each weak row in one or more small Bloom filters, one filter per retention bin. It does this through a configuration stream that is accepted only while the scheduler is stopped. A later refresh rate cannot start until binning has finished.

Once enabled, a row pointer visits every row once per base period, one row per cycle. The block asks the filters which bin the current row belongs to. A row found in no filter belongs to the slowest default class. The block then checks whether that class is due in the current period. Due rows leave as a valid/ready request stream carrying the row address. The command arbiter may hold back `ref_ready` for as long as it likes. While it does, the request stays put and the row pointer waits, so no row is ever skipped.

Top module: `refbin_sched`

## Requirements
- R1: After reset `ref_valid` is 0 and `ref_row` is 0. The row pointer and the 2-bit period counter both start at 0. With `run_en` low, `cfg_ins_ready` is 1.
- R2: Each filter is a 32-bit vector with two hash indices. Index j comes from rotating the 6-bit row address left by j places. Row bit b of that rotated value is then XORed into index bit (b mod 5). An insert sets both indexed bits. A query hits only when both are set.
- R3: A row that hits filter 0 is class 0. Otherwise a row that hits filter 1 is class 1. A row in neither filter is class 2. When a row hits several filters, the lowest class wins.
- R4: A row of class c is requested only in periods whose period-counter value has its low c bits at zero. The counter increments when the pointer moves past row 63.
- R5: While `run_en` is high and no request is stalled, one row is examined per clock. A due row's request appears on the cycle after the one in which it was examined.
- R6: A request with `ref_ready` low keeps `ref_valid` and `ref_row` unchanged, and the row pointer does not advance. The next row is examined on the same edge that completes the handshake.
- R7: `cfg_ins_ready` is high only when `run_en` is low and no request is outstanding. An insert (`cfg_ins_valid` with `cfg_ins_bin` choosing the filter) offered at any other time has no effect on later requests.
- R8: `cfg_clear`, taken while idle, empties every filter. After that, every row is class 2.
- R9: With `run_en` low, no new request is raised. A pending request still completes its handshake.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| run_en | input | 1 | Enables the row walk and refresh issue |
| cfg_clear | input | 1 | Empties all filters when idle |
| cfg_ins_valid | input | 1 | Insert request valid |
| cfg_ins_ready | output | 1 | Insert accepted this cycle (scheduler idle) |
| cfg_ins_bin | input | 1 | Filter selected for the insert |
| cfg_ins_row | input | 6 | Row address to insert |
| ref_valid | output | 1 | Refresh request valid |
| ref_ready | input | 1 | Arbiter accepts the refresh request |
| ref_row | output | 6 | Row address to refresh |

## Verification
A request is due exactly one cycle after its row is examined. With `ref_ready` held high, row r of period p therefore shows up on the (64·p + r + 1)-th falling edge after `run_en` rises. The bench compares both the address and that cycle number against a model of the filters and classes, and samples only on falling edges. Inserts and clears take effect at the next rising edge. Their results are checked through the request stream of a later period, and a stalled request is sampled on each cycle of the stall. Wherever a register sits between a stimulus and its result, the bench waits exactly one edge before sampling.

// File: rtl/refbin_pkg.sv
package refbin_pkg;

  // True when every bit of v below position n is zero (period due test).
  function automatic logic low_bits_clear(input logic [15:0] v, input int n);
    logic ok;
    ok = 1'b1;
    for (int i = 0; i < 16; i++) begin
      if (i < n && v[i]) ok = 1'b0;
    end
    return ok;
  endfunction

  // Index of the first set bit of v, or dflt when none is set.
  function automatic int first_set(input logic [15:0] v, input int width, input int dflt);
    int r;
    r = dflt;
    for (int i = 15; i >= 0; i--) begin
      if (i < width && v[i]) r = i;
    end
    return r;
  endfunction

endpackage

// File: rtl/refbin_bloom.sv
module refbin_bloom #(
  parameter int ROW_W  = 6,
  parameter int FILT_M = 32,
  parameter int HASH_K = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear_i,
  input  logic             ins_i,
  input  logic [ROW_W-1:0] ins_row_i,
  input  logic [ROW_W-1:0] qry_row_i,
  output logic             hit_o
);
  localparam int IDX_W = $clog2(FILT_M);

  logic [FILT_M-1:0] bits_q;

  // Rotate left by s, then fold row bit b onto index bit (b mod IDX_W).
  function automatic logic [IDX_W-1:0] hidx(input logic [ROW_W-1:0] r, input int s);
    logic [ROW_W-1:0] rr;
    logic [IDX_W-1:0] acc;
    rr  = r;
    for (int n = 0; n < HASH_K; n++) begin
      if (n < s) rr = {rr[ROW_W-2:0], rr[ROW_W-1]};
    end
    acc = '0;
    for (int b = 0; b < ROW_W; b++) begin
      acc[b % IDX_W] = acc[b % IDX_W] ^ rr[b];
    end
    return acc;
  endfunction

  always_comb begin
    hit_o = 1'b1;
    for (int j = 0; j < HASH_K; j++) begin
      hit_o = hit_o & bits_q[hidx(qry_row_i, j)];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clear_i) begin
      bits_q <= '0;
    end else if (ins_i) begin
      for (int j = 0; j < HASH_K; j++) begin
        bits_q[hidx(ins_row_i, j)] <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/refbin_walker.sv
module refbin_walker #(
  parameter int ROW_W = 6,
  parameter int PER_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step_i,
  output logic [ROW_W-1:0] row_o,
  output logic [PER_W-1:0] period_o
);
  localparam logic [ROW_W-1:0] LAST_ROW = '1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      row_o    <= '0;
      period_o <= '0;
    end else if (step_i) begin
      row_o <= row_o + 1'b1;
      if (row_o == LAST_ROW) period_o <= period_o + 1'b1;
    end
  end

endmodule

// File: rtl/refbin_issuer.sv
module refbin_issuer #(
  parameter int ROW_W    = 6,
  parameter int NUM_BINS = 2,
  parameter int PER_W    = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                run_i,
  input  logic [NUM_BINS-1:0] hit_i,
  input  logic [ROW_W-1:0]    row_i,
  input  logic [PER_W-1:0]    period_i,
  input  logic                ready_i,
  output logic                step_o,
  output logic                valid_o,
  output logic [ROW_W-1:0]    row_o
);
  import refbin_pkg::*;

  int   cls;
  logic due;

  always_comb begin
    cls = first_set(16'(hit_i), NUM_BINS, NUM_BINS);
    due = low_bits_clear(16'(period_i), cls);
  end

  assign step_o = run_i && (!valid_o || ready_i);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_o <= 1'b0;
      row_o   <= '0;
    end else if (step_o) begin
      valid_o <= due;
      if (due) row_o <= row_i;
    end else if (valid_o && ready_i) begin
      valid_o <= 1'b0;
    end
  end

endmodule

// File: rtl/refbin_sched.sv
module refbin_sched #(
  parameter int ROW_W    = 6,
  parameter int FILT_M   = 32,
  parameter int HASH_K   = 2,
  parameter int NUM_BINS = 2
) (
  input  logic                                         clk,
  input  logic                                         rst_n,
  input  logic                                         run_en,
  input  logic                                         cfg_clear,
  input  logic                                         cfg_ins_valid,
  output logic                                         cfg_ins_ready,
  input  logic [((NUM_BINS > 1) ? $clog2(NUM_BINS) : 1)-1:0] cfg_ins_bin,
  input  logic [ROW_W-1:0]                             cfg_ins_row,
  output logic                                         ref_valid,
  input  logic                                         ref_ready,
  output logic [ROW_W-1:0]                             ref_row
);
  localparam int BIN_W = (NUM_BINS > 1) ? $clog2(NUM_BINS) : 1;
  localparam int PER_W = NUM_BINS;

  logic                idle;
  logic [NUM_BINS-1:0] hit_vec;
  logic [ROW_W-1:0]    walk_row;
  logic [PER_W-1:0]    walk_period;
  logic                step;

  assign idle          = !run_en && !ref_valid;
  assign cfg_ins_ready = idle;

  for (genvar g = 0; g < NUM_BINS; g++) begin : g_filt
    refbin_bloom #(
      .ROW_W (ROW_W),
      .FILT_M(FILT_M),
      .HASH_K(HASH_K)
    ) u_filt (
      .clk      (clk),
      .rst_n    (rst_n),
      .clear_i  (cfg_clear && idle),
      .ins_i    (cfg_ins_valid && idle && (cfg_ins_bin == BIN_W'(g))),
      .ins_row_i(cfg_ins_row),
      .qry_row_i(walk_row),
      .hit_o    (hit_vec[g])
    );
  end

  refbin_walker #(
    .ROW_W(ROW_W),
    .PER_W(PER_W)
  ) u_walk (
    .clk     (clk),
    .rst_n   (rst_n),
    .step_i  (step),
    .row_o   (walk_row),
    .period_o(walk_period)
  );

  refbin_issuer #(
    .ROW_W   (ROW_W),
    .NUM_BINS(NUM_BINS),
    .PER_W   (PER_W)
  ) u_issue (
    .clk     (clk),
    .rst_n   (rst_n),
    .run_i   (run_en),
    .hit_i   (hit_vec),
    .row_i   (walk_row),
    .period_i(walk_period),
    .ready_i (ref_ready),
    .step_o  (step),
    .valid_o (ref_valid),
    .row_o   (ref_row)
  );

endmodule

// File: rtl/refbin_sched_chk.sv
module refbin_sched_chk #(
  parameter int ROW_W    = 6,
  parameter int NUM_BINS = 2
) (
  input logic                clk,
  input logic                rst_n,
  input logic                run_en,
  input logic                ref_valid,
  input logic                ref_ready,
  input logic [ROW_W-1:0]    ref_row,
  input logic [ROW_W-1:0]    walk_row,
  input logic [NUM_BINS-1:0] walk_period,
  input logic [NUM_BINS-1:0] hit_vec,
  input logic                step
);

  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ref_valid && !ref_ready |=> ref_valid && $stable(ref_row));

  p_walk_stall_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ref_valid && !ref_ready |=> $stable(walk_row));

  p_walk_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    run_en && !ref_valid |=> walk_row == ROW_W'($past(walk_row) + 1'b1));

  p_bin0_every_r3: assert property (@(posedge clk) disable iff (!rst_n)
    step && hit_vec[0] |=> ref_valid && ref_row == $past(walk_row));

  p_default_skip_r4: assert property (@(posedge clk) disable iff (!rst_n)
    step && hit_vec == '0 && walk_period != '0 |=> !ref_valid);

  p_quiet_stop_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !run_en && !ref_valid |=> !ref_valid);

endmodule

bind refbin_sched refbin_sched_chk #(
  .ROW_W   (ROW_W),
  .NUM_BINS(NUM_BINS)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .run_en     (run_en),
  .ref_valid  (ref_valid),
  .ref_ready  (ref_ready),
  .ref_row    (ref_row),
  .walk_row   (walk_row),
  .walk_period(walk_period),
  .hit_vec    (hit_vec),
  .step       (step)
);

// File: tb/test_refbin_sched.sv
module test_refbin_sched;
  localparam int ROWS = 64;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       run_en = 1'b0;
  logic       cfg_clear = 1'b0;
  logic       cfg_ins_valid = 1'b0;
  logic       cfg_ins_ready;
  logic       cfg_ins_bin = 1'b0;
  logic [5:0] cfg_ins_row = '0;
  logic       ref_valid;
  logic       ref_ready = 1'b0;
  logic [5:0] ref_row;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  refbin_sched i_refbin_sched (
    .clk(clk), .rst_n(rst_n), .run_en(run_en), .cfg_clear(cfg_clear),
    .cfg_ins_valid(cfg_ins_valid), .cfg_ins_ready(cfg_ins_ready),
    .cfg_ins_bin(cfg_ins_bin), .cfg_ins_row(cfg_ins_row),
    .ref_valid(ref_valid), .ref_ready(ref_ready), .ref_row(ref_row)
  );

  // {bin, row}: row 5 sits in both filters.
  localparam logic [6:0] INS_TAB [8] = '{
    {1'b0, 6'd5},  {1'b0, 6'd40}, {1'b0, 6'd17}, {1'b1, 6'd9},
    {1'b1, 6'd33}, {1'b1, 6'd62}, {1'b1, 6'd5},  {1'b1, 6'd20}
  };

  logic [31:0] mflt [2];
  int exp_row [1024];
  int exp_cyc [1024];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  // R2 index: rotate left by s, fold bit b onto index bit b mod 5
  function automatic int midx(input logic [5:0] r, input int s);
    logic [5:0] rr;
    logic [4:0] a;
    rr = r;
    for (int n = 0; n < s; n++) rr = {rr[4:0], rr[5]};
    a = '0;
    for (int b = 0; b < 6; b++) a[b % 5] ^= rr[b];
    return int'(a);
  endfunction

  function automatic bit mhit(input int f, input logic [5:0] r);
    return mflt[f][midx(r, 0)] && mflt[f][midx(r, 1)];
  endfunction

  function automatic int mcls(input logic [5:0] r);
    if (mhit(0, r)) return 0;
    if (mhit(1, r)) return 1;
    return 2;
  endfunction

  task automatic ins(input logic b, input logic [5:0] r);
    @(negedge clk);
    chk(cfg_ins_ready == 1'b1, "R7 ready while idle", cfg_ins_ready, 1);
    cfg_ins_valid = 1'b1; cfg_ins_bin = b; cfg_ins_row = r;
    @(negedge clk);
    cfg_ins_valid = 1'b0;
    mflt[b][midx(r, 0)] = 1'b1;
    mflt[b][midx(r, 1)] = 1'b1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R5 watchdog act=running exp=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int n_exp;
    int k;
    int cnt;
    mflt[0] = '0; mflt[1] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(ref_valid == 1'b0, "R1 valid after reset", ref_valid, 0);
    chk(ref_row == 6'd0, "R1 row after reset", ref_row, 0);
    chk(cfg_ins_ready == 1'b1, "R1 insert ready when stopped", cfg_ins_ready, 1);

    // R2 R3 configuration from the vector table
    for (int i = 0; i < 8; i++) ins(INS_TAB[i][6], INS_TAB[i][5:0]);

    // expected stream over 8 periods (R3 R4 R5)
    n_exp = 0;
    for (int p = 0; p < 8; p++) begin
      for (int r = 0; r < ROWS; r++) begin
        int c;
        c = mcls(6'(r));
        if ((p % (1 << c)) == 0) begin
          exp_row[n_exp] = r;
          exp_cyc[n_exp] = p * ROWS + r + 1;
          n_exp++;
        end
      end
    end

    run_en = 1'b1; ref_ready = 1'b1;
    k = 0;
    for (int c = 1; c <= 8 * ROWS; c++) begin
      @(negedge clk);
      if (ref_valid) begin
        if (k < n_exp) begin
          chk(int'(ref_row) == exp_row[k], "R4 row order", int'(ref_row), exp_row[k]);
          chk(c == exp_cyc[k], "R5 request cycle", c, exp_cyc[k]);
        end else begin
          chk(1'b0, "R3 extra request", int'(ref_row), -1);
        end
        k++;
      end
      if (c == 70) begin
        chk(cfg_ins_ready == 1'b0, "R7 not ready while running", cfg_ins_ready, 0);
        cfg_ins_valid = 1'b1; cfg_ins_bin = 1'b0; cfg_ins_row = 6'd50;
      end
      if (c == 71) cfg_ins_valid = 1'b0;
    end
    chk(k == n_exp, "R4 request count", k, n_exp);

    // R9 stop
    run_en = 1'b0;
    repeat (2) @(negedge clk);
    chk(ref_valid == 1'b0, "R9 no request when stopped", ref_valid, 0);
    chk(cfg_ins_ready == 1'b1, "R7 ready after stop", cfg_ins_ready, 1);
    cnt = 0;
    repeat (5) begin
      @(negedge clk);
      if (ref_valid) cnt++;
    end
    chk(cnt == 0, "R9 stays quiet", cnt, 0);

    // R8 clear, then R6 stall
    cfg_clear = 1'b1;
    @(negedge clk);
    cfg_clear = 1'b0; run_en = 1'b1; ref_ready = 1'b0;
    @(negedge clk);
    chk(ref_valid == 1'b1, "R6 request raised", ref_valid, 1);
    chk(ref_row == 6'd0, "R6 first row", int'(ref_row), 0);
    for (int s = 0; s < 3; s++) begin
      @(negedge clk);
      chk(ref_valid == 1'b1 && ref_row == 6'd0, "R6 held during stall", int'(ref_row), 0);
    end
    ref_ready = 1'b1;
    @(negedge clk);
    chk(ref_valid == 1'b1 && ref_row == 6'd1, "R6 no row skipped", int'(ref_row), 1);
    cnt = 0;
    for (int s = 0; s < 200; s++) begin
      @(negedge clk);
      if (ref_valid) cnt++;
    end
    chk(cnt == 62, "R8 cleared rows all default class", cnt, 62);

    // R1 reset while running
    rst_n = 1'b0;
    @(negedge clk);
    chk(ref_valid == 1'b0, "R1 valid in reset", ref_valid, 0);
    chk(ref_row == 6'd0, "R1 row in reset", int'(ref_row), 0);
    run_en = 1'b0;
    @(negedge clk);
    chk(cfg_ins_ready == 1'b1, "R1 ready in reset", cfg_ins_ready, 1);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule